// File: doc/BRIEF.md
# Microcoded Two-Bit Up/Down Counter Sequencer

This block produces a two-bit count that moves up, moves down or holds, as set by an enable input and a direction input. It does not use a counter circuit. A five-bit microprogram address register steps through a 32-word by 8-bit microcode store. Each microword does one of two things. It loads the two-bit output register, or it performs a conditional jump. A jump picks one of four conditions: enable-and-up, not-enable, never, or always.

The microprogram gives each count value a group of four words, in this order:
- load the value;
- park on a hold word while the enable is low;
- branch to the next-higher group when enabled and counting up;
- otherwise branch to the next-lower group.

Because of this layout, an up step takes three clocks and a down step takes four. The current microprogram address is brought out with the count. This lets a controller or a bench see where the sequencer is.

Top module: `useq_updown_counter`

## Requirements
- R1: A synchronous reset clears the microprogram address and the count output to 0 at the next rising clock edge.
- R2: A microword with bit 7 clear loads the count output from bits 1:0 at the end of the cycle in which it is executed. The count output changes at no other time.
- R3: A microword with bit 7 set is a jump. Bits 6:5 select the condition: 00 means enable AND up, 01 means NOT enable, and 11 means always taken.
- R4: When the selected condition is true, the address takes the target in bits 4:0. Otherwise, and after every load word, the address advances by one.
- R5: While enable is low, the sequencer stays on the hold word of its current group (address 4*count+1), and the count output does not change.
- R6: With enable high and up high, the count increments once every three clocks and wraps from 3 to 0.
- R7: With enable high and up low, the count decrements once every four clocks and wraps from 0 to 3.
- R8: The store holds 00 A1 84 EC 01 A5 88 E0 02 A9 8C E4 03 AD 80 E8 (hex) at addresses 0 to 15 and 0 at addresses 16 to 31. The address therefore never leaves the range 0 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cntEn | input | 1 | Counting enable; low parks the sequencer |
| countUp | input | 1 | Direction: high counts up, low counts down |
| q | output | 2 | Registered count value |
| uAddr | output | 5 | Current microprogram address |

## Verification
Every result is registered. The address reflects a jump or an increment one edge after the microword is presented. The count output reflects a load word one edge after that word is addressed, so the count trails its group's first address by exactly one clock. The bench drives enable and direction on the falling edge. It advances a behavioural phase-and-count model on the rising edge, and compares both outputs on the next falling edge. The bench also measures the clocks between successive count changes, expecting three on up runs and four on down runs. It skips the first change after each change of scenario.

// File: rtl/useq_pkg.sv
package useq_pkg;

  // Strobes from the control section to the output datapath
  typedef struct packed {
    logic loadOut;   // load the count register this cycle
    logic takeJump;  // the jump condition is met this cycle
  } seqStrobe_t;

  // Jump condition selector encodings (microword bits 6:5)
  typedef enum logic [1:0] {
    COND_RUN_UP = 2'b00,
    COND_IDLE   = 2'b01,
    COND_NEVER  = 2'b10,
    COND_ALWAYS = 2'b11
  } condSel_t;

  localparam int unsigned WORDS_PER_STATE = 4;

endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 2
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [ADDR_W+2:0]   word
);

  localparam int unsigned WORD_W     = ADDR_W + 3;
  localparam int unsigned ROM_DEPTH  = 1 << ADDR_W;
  localparam int unsigned STATES     = 1 << CNT_W;
  localparam int unsigned PROG_WORDS = STATES * WORDS_PER_STATE;
  localparam int unsigned SEL_LO     = ADDR_W;
  localparam int unsigned SEL_HI     = ADDR_W + 1;

  // Build one microword of the counting program; words past the program are zero
  function automatic logic [WORD_W-1:0] calcWord(input int unsigned idx);
    logic [WORD_W-1:0] w;
    int unsigned grp, phase, upGrp, dnGrp;
    w = '0;
    if (idx < PROG_WORDS) begin
      grp   = idx / WORDS_PER_STATE;
      phase = idx % WORDS_PER_STATE;
      upGrp = (grp + 1) % STATES;
      dnGrp = (grp + STATES - 1) % STATES;
      case (phase)
        0: w[CNT_W-1:0] = CNT_W'(grp);
        1: begin
          w[WORD_W-1]        = 1'b1;
          w[SEL_HI:SEL_LO]   = COND_IDLE;
          w[ADDR_W-1:0]      = ADDR_W'(idx);
        end
        2: begin
          w[WORD_W-1]        = 1'b1;
          w[SEL_HI:SEL_LO]   = COND_RUN_UP;
          w[ADDR_W-1:0]      = ADDR_W'(upGrp * WORDS_PER_STATE);
        end
        default: begin
          w[WORD_W-1]        = 1'b1;
          w[SEL_HI:SEL_LO]   = COND_ALWAYS;
          w[ADDR_W-1:0]      = ADDR_W'(dnGrp * WORDS_PER_STATE);
        end
      endcase
    end
    return w;
  endfunction

  logic [WORD_W-1:0] romTable [ROM_DEPTH];

  for (genvar i = 0; i < ROM_DEPTH; i++) begin : g_rom
    assign romTable[i] = calcWord(i);
  end

  assign word = romTable[addr];

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cntEn,
  input  logic                countUp,
  input  logic [ADDR_W+2:0]   romWord,
  output logic [ADDR_W-1:0]   pc,
  output seqStrobe_t          strobe,
  output logic [CNT_W-1:0]    loadVal
);

  localparam int unsigned WORD_W     = ADDR_W + 3;
  localparam int unsigned SEL_LO     = ADDR_W;
  localparam int unsigned SEL_HI     = ADDR_W + 1;
  localparam int unsigned PROG_WORDS = (1 << CNT_W) * WORDS_PER_STATE;

  logic [ADDR_W-1:0] pcQ;
  condSel_t          condSel;
  logic              condTrue;
  logic              isJump;

  assign isJump  = romWord[WORD_W-1];
  assign condSel = condSel_t'(romWord[SEL_HI:SEL_LO]);

  // Condition multiplexer
  always_comb begin
    case (condSel)
      COND_RUN_UP: condTrue = cntEn & countUp;
      COND_IDLE:   condTrue = ~cntEn;
      COND_ALWAYS: condTrue = 1'b1;
      default:     condTrue = 1'b0;
    endcase
  end

  assign strobe.loadOut  = ~isJump;
  assign strobe.takeJump = isJump & condTrue;
  assign loadVal         = romWord[CNT_W-1:0];

  // Microprogram address register: jump or advance
  always_ff @(posedge clk) begin
    if (rst)                  pcQ <= '0;
    else if (strobe.takeJump) pcQ <= romWord[ADDR_W-1:0];
    else                      pcQ <= pcQ + ADDR_W'(1);
  end

  assign pc = pcQ;

  // R1: reset parks the address at 0
  p_reset_pc_r1: assert property (@(posedge clk) rst |=> pcQ == '0);

  // R5: a hold word with enable low keeps the address in place
  p_hold_park_r5: assert property (@(posedge clk) disable iff (rst)
    (pcQ[1:0] == 2'b01 && !cntEn) |=> $stable(pcQ));

  // R3: the up-check word moves to the first word of a group when enabled upward
  p_up_branch_r3: assert property (@(posedge clk) disable iff (rst)
    (pcQ[1:0] == 2'b10 && cntEn && countUp) |=> pcQ[1:0] == 2'b00);

  // R8: execution never leaves the programmed region
  p_in_program_r8: assert property (@(posedge clk) disable iff (rst)
    {1'b0, pcQ} < (ADDR_W+1)'(PROG_WORDS));

endmodule

// File: rtl/useq_datapath.sv
module useq_datapath
  import useq_pkg::*;
#(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  seqStrobe_t       strobe,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] q
);

  logic [CNT_W-1:0] qReg;

  always_ff @(posedge clk) begin
    if (rst)                 qReg <= '0;
    else if (strobe.loadOut) qReg <= loadVal;
  end

  assign q = qReg;

  // R1: the count clears on reset
  p_reset_q_r1: assert property (@(posedge clk) rst |=> qReg == '0);

  // R2: a jump word never disturbs the count
  p_q_steady_r2: assert property (@(posedge clk) disable iff (rst)
    strobe.takeJump |=> $stable(qReg));

endmodule

// File: rtl/useq_updown_counter.sv
module useq_updown_counter
  import useq_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cntEn,
  input  logic              countUp,
  output logic [CNT_W-1:0]  q,
  output logic [ADDR_W-1:0] uAddr
);

  localparam int unsigned WORD_W = ADDR_W + 3;

  logic [WORD_W-1:0] romWord;
  logic [ADDR_W-1:0] pc;
  seqStrobe_t        strobe;
  logic [CNT_W-1:0]  loadVal;

  useq_rom #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rom (
    .addr (pc),
    .word (romWord)
  );

  useq_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cntEn   (cntEn),
    .countUp (countUp),
    .romWord (romWord),
    .pc      (pc),
    .strobe  (strobe),
    .loadVal (loadVal)
  );

  useq_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .loadVal (loadVal),
    .q       (q)
  );

  assign uAddr = pc;

  // R6 and R7: every change of the count is a single step with wrap
  p_unit_step_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(q) |-> (q == $past(q) + CNT_W'(1) || q == $past(q) - CNT_W'(1)));

endmodule

// File: tb/tb_useq_updown_counter.sv
module tb_useq_updown_counter;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cntEn = 1'b0;
  logic       countUp = 1'b0;
  logic [1:0] q;
  logic [4:0] uAddr;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // Behavioural reference: group index and position inside the group
  int mGrp = 0;
  int mPhase = 0;
  int mQ = 0;

  string tag = "R1";
  int cyc = 0;
  int lastChg = 0;
  int changesSeen = 0;
  int prevQ = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  useq_updown_counter dut (
    .clk(clk), .rst(rst), .cntEn(cntEn), .countUp(countUp),
    .q(q), .uAddr(uAddr)
  );

  task automatic modelStep();
    if (rst) begin
      mGrp = 0; mPhase = 0; mQ = 0;
    end else begin
      case (mPhase)
        0: begin mQ = mGrp; mPhase = 1; end           // R2 load
        1: if (cntEn) mPhase = 2;                      // R5 park while disabled
        2: if (cntEn && countUp) begin                 // R3 up branch
             mGrp = (mGrp + 1) % 4; mPhase = 0;
           end else mPhase = 3;
        default: begin mGrp = (mGrp + 3) % 4; mPhase = 0; end
      endcase
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic compareAll();
    int expAddr;
    expAddr = mGrp * 4 + mPhase;
    check(q == 2'(mQ), {tag, " R2 count"}, q, mQ);
    check(uAddr == 5'(expAddr), {tag, " R4 R8 address"}, uAddr, expAddr);
    if (!rst && int'(q) != prevQ) begin
      changesSeen++;
      if (changesSeen > 1 && tag == "R6") check(cyc - lastChg == 3, "R6 step period", cyc - lastChg, 3);
      if (changesSeen > 1 && tag == "R7") check(cyc - lastChg == 4, "R7 step period", cyc - lastChg, 4);
      lastChg = cyc;
    end
    prevQ = q;
  endtask

  task automatic runCycles(input int n, input bit en, input bit up, input bit rs,
                           input string t, input bit rnd);
    tag = t;
    changesSeen = 0;
    for (int i = 0; i < n; i++) begin
      if (rnd) begin
        cntEn = ($urandom % 4) != 0;
        countUp = $urandom % 2;
      end else begin
        cntEn = en;
        countUp = up;
      end
      rst = rs;
      @(posedge clk);
      modelStep();
      cyc++;
      @(negedge clk);
      compareAll();
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    runCycles(3, 1'b1, 1'b1, 1'b1, "R1", 1'b0);     // reset state
    runCycles(40, 1'b1, 1'b1, 1'b0, "R6", 1'b0);    // up with wrap 3 -> 0
    runCycles(45, 1'b1, 1'b0, 1'b0, "R7", 1'b0);    // down with wrap 0 -> 3
    runCycles(12, 1'b0, 1'b1, 1'b0, "R5", 1'b0);    // parked
    runCycles(20, 1'b1, 1'b0, 1'b0, "R7", 1'b0);
    runCycles(9, 1'b0, 1'b0, 1'b0, "R5", 1'b0);
    runCycles(300, 1'b0, 1'b0, 1'b0, "R3", 1'b1);   // mixed condition patterns
    runCycles(2, 1'b1, 1'b1, 1'b1, "R1", 1'b0);     // reset mid-run
    runCycles(30, 1'b1, 1'b1, 1'b0, "R6", 1'b0);
    runCycles(200, 1'b0, 1'b0, 1'b0, "R8", 1'b1);   // address trace over the stored program
    summary();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog expired: actual %0d expected %0d cycles", WATCHDOG, cyc);
    summary();
  end

endmodule